// File: doc/BRIEF.md
# Page-Buffered Serial EEPROM Target Core

This core is the byte-level behaviour of a two-wire serial EEPROM target. It sits behind a bus front end that has already turned pin activity into single-cycle events: a start, a stop, a received byte, and the master's acknowledge or refusal after a byte the core has sent. The core selects itself from the control byte and three strap inputs. It then loads a two-byte word address and collects write data in a page buffer. A stop commits the buffered bytes to a RAM-backed array during a timed internal write cycle, unless the write-protect input is high. Sequential reads are served from the current address pointer.

The front end answers each received byte with the core's decision. That decision arrives one cycle after the byte as a pulse on `ack_vld`, with `ack` high when the core acknowledges. Read data comes out on `tx_data`, qualified by a one-cycle `tx_vld` pulse. `busy` is high for the whole internal write cycle. While it is high the core takes part in nothing on the bus. The page size must be a power of two, and the write-cycle length `TWC` must be larger than the page size, because the commit moves one buffered byte per cycle. The array holds 2^`MEM_AW` bytes. Word-address bits above that width are dropped, so the array repeats through the 16-bit address space.

Top module: `ee_target_core`

## Requirements
- R1: A control byte selects the core only when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap`. Bit 0 gives the direction (0 = write, 1 = read). A non-matching control byte is not acknowledged, and every following byte is refused until the next start.
- R2: When the core is not busy and has been selected after a start, it acknowledges each control, address and write-data byte. For every received byte `ack_vld` pulses one cycle later, and `ack` is 1 only for an acknowledged byte.
- R3: The high address byte comes first and the low address byte second. The lower `MEM_AW` bits of the 16-bit word address set the pointer, so addresses that differ only above bit `MEM_AW`-1 reach the same cell.
- R4: Write data goes to the current column. After each byte the column advances inside the page and the page never changes, so a byte past the last column lands on column 0 of the same page.
- R5: A stop after one to `PAGE` or more data bytes commits the bytes of that operation. Where a column was written more than once, the last byte wins. Cells not written in the operation keep their contents.
- R6: If `wp` is 1 when the stop arrives, no write cycle starts, `busy` stays 0 and the array does not change.
- R7: A committed stop raises `busy` in the next cycle and holds it for exactly `TWC` cycles. While `busy` is high, starts, stops, bytes and master responses are ignored, and every byte is answered with `ack` = 0.
- R8: A read control byte sends the byte at the pointer one cycle later on `tx_data` with a `tx_vld` pulse and advances the pointer. Each master acknowledge (`ev_mack_ack` = 1) sends the next byte. The pointer runs across the whole array and wraps from the last address to 0. A master refusal ends the read.
- R9: A start that arrives after write data but before the stop discards that data. A write that sends only the address and then stops starts no write cycle.
- R10: After reset `ack_vld`, `ack`, `tx_vld` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_start | input | 1 | Start (or repeated start) event, one cycle |
| ev_stop | input | 1 | Stop event, one cycle |
| ev_byte_vld | input | 1 | A byte from the master is present on `ev_byte` |
| ev_byte | input | 8 | Received byte |
| ev_mack_vld | input | 1 | Master response after a byte sent by the core |
| ev_mack_ack | input | 1 | 1 = master acknowledged, 0 = master refused |
| strap | input | 3 | Chip-address straps |
| wp | input | 1 | Write protect, sampled at the stop |
| ack_vld | output | 1 | Response to a received byte is valid |
| ack | output | 1 | 1 = acknowledge the byte |
| tx_vld | output | 1 | `tx_data` holds a byte to send |
| tx_data | output | 8 | Read data byte |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The assertions assume that the front end raises at most one event per cycle, and that it raises master responses only while a read is in progress. The response checks also assume that the straps and `wp` stay steady across a transaction. The bench drives every event through a single one-event-per-cycle task, changes the straps only between transactions, and changes `wp` only while no stop is pending. It reads back only cells it has written before, so unwritten array contents never reach a comparison.

// File: rtl/ee_target_pkg.sv
package ee_target_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDATA,
    ST_RDATA
  } ee_state_t;
endpackage

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int PAGE  = 128,
  localparam int COL_W = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [COL_W-1:0] wcol,
  input  logic [7:0]       wdata,
  input  logic [COL_W-1:0] rcol,
  output logic [7:0]       rdata,
  output logic             rmask
);
  logic [7:0]      data_q [PAGE];
  logic [PAGE-1:0] mask_q;
  logic [PAGE-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (clr) mask_d = '0;
    else if (we) mask_d[wcol] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  always_ff @(posedge clk) begin
    if (we) data_q[wcol] <= wdata;
  end

  assign rdata = data_q[rcol];
  assign rmask = mask_q[rcol];
endmodule

// File: rtl/ee_wr_timer.sv
module ee_wr_timer #(
  parameter int TWC   = 160,
  parameter int PAGE  = 128,
  localparam int CNT_W = $clog2(TWC),
  localparam int COL_W = $clog2(PAGE)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy,
  output logic             commit_act,
  output logic [COL_W-1:0] commit_col
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [COL_W:0]   idx_q, idx_d;
  logic             busy_d;

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (launch) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(TWC - 1);
      idx_d  = '0;
    end else if (busy) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
      if (commit_act) idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end

  assign commit_act = busy && !idx_q[COL_W];
  assign commit_col = idx_q[COL_W-1:0];

  // R7: the cycle never runs past TWC cycles
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_q == '0 |=> !busy || $past(launch));
endmodule

// File: rtl/ee_array.sv
module ee_array #(
  parameter int MEM_AW = 10,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [MEM_AW-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/ee_target_core.sv
module ee_target_core
  import ee_target_pkg::*;
#(
  parameter int          PAGE     = 128,
  parameter int          MEM_AW   = 10,
  parameter int          TWC      = 160,
  parameter logic [3:0]  DEV_CODE = 4'b1010,
  localparam int COL_W = $clog2(PAGE)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_byte_vld,
  input  logic [7:0] ev_byte,
  input  logic       ev_mack_vld,
  input  logic       ev_mack_ack,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       ack_vld,
  output logic       ack,
  output logic       tx_vld,
  output logic [7:0] tx_data,
  output logic       busy
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  ee_state_t         state, state_d;
  logic [MEM_AW-1:0] ptr, ptr_d;
  logic [7:0]        ahi, ahi_d;
  logic              has_data, has_data_d;
  logic              accept, launch, buf_we, buf_clr, rd_adv;
  logic [15:0]       word_addr;
  logic [COL_W-1:0]  col_inc;
  logic [7:0]        arr_rdata, buf_rdata;
  logic              buf_rmask, commit_act, arr_we;
  logic [COL_W-1:0]  commit_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  assign word_addr = {ahi, ev_byte};
  assign col_inc   = ptr[COL_W-1:0] + 1'b1;

  always_comb begin
    state_d    = state;
    ptr_d      = ptr;
    ahi_d      = ahi;
    has_data_d = has_data;
    accept     = 1'b0;
    launch     = 1'b0;
    buf_we     = 1'b0;
    buf_clr    = 1'b0;
    rd_adv     = 1'b0;
    if (!busy) begin
      if (ev_start) begin
        state_d = ST_CTRL;
      end else if (ev_stop) begin
        if (state == ST_WDATA && has_data && !wp) launch = 1'b1;
        state_d = ST_IDLE;
      end else if (ev_byte_vld) begin
        case (state)
          ST_CTRL: begin
            if (ev_byte[7:4] == DEV_CODE && ev_byte[3:1] == strap) begin
              accept = 1'b1;
              if (ev_byte[0]) begin
                state_d = ST_RDATA;
                rd_adv  = 1'b1;
              end else begin
                state_d = ST_AHI;
              end
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_AHI: begin
            accept  = 1'b1;
            ahi_d   = ev_byte;
            state_d = ST_ALO;
          end
          ST_ALO: begin
            accept     = 1'b1;
            ptr_d      = word_addr[MEM_AW-1:0];
            buf_clr    = 1'b1;
            has_data_d = 1'b0;
            state_d    = ST_WDATA;
          end
          ST_WDATA: begin
            accept     = 1'b1;
            buf_we     = 1'b1;
            has_data_d = 1'b1;
            ptr_d      = {ptr[MEM_AW-1:COL_W], col_inc};
          end
          default: ;
        endcase
      end else if (ev_mack_vld && state == ST_RDATA) begin
        if (ev_mack_ack) rd_adv  = 1'b1;
        else             state_d = ST_IDLE;
      end
    end
    if (rd_adv) ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state    <= ST_IDLE;
      ptr      <= '0;
      ahi      <= '0;
      has_data <= 1'b0;
      ack_vld  <= 1'b0;
      ack      <= 1'b0;
      tx_vld   <= 1'b0;
      tx_data  <= '0;
    end else begin
      state    <= state_d;
      ptr      <= ptr_d;
      ahi      <= ahi_d;
      has_data <= has_data_d;
      ack_vld  <= ev_byte_vld;
      ack      <= accept;
      tx_vld   <= rd_adv;
      if (rd_adv) tx_data <= arr_rdata;
    end
  end

  ee_page_buf #(.PAGE(PAGE)) u_buf (
    .clk   (clk),
    .rst_n (rst_q),
    .clr   (buf_clr),
    .we    (buf_we),
    .wcol  (ptr[COL_W-1:0]),
    .wdata (ev_byte),
    .rcol  (commit_col),
    .rdata (buf_rdata),
    .rmask (buf_rmask)
  );

  ee_wr_timer #(.TWC(TWC), .PAGE(PAGE)) u_timer (
    .clk        (clk),
    .rst_n      (rst_q),
    .launch     (launch),
    .busy       (busy),
    .commit_act (commit_act),
    .commit_col (commit_col)
  );

  assign arr_we = commit_act && buf_rmask;

  ee_array #(.MEM_AW(MEM_AW)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({ptr[MEM_AW-1:COL_W], commit_col}),
    .wdata (buf_rdata),
    .raddr (ptr),
    .rdata (arr_rdata)
  );

  // R1: a foreign control byte is never acknowledged
  a_r1_strap_miss: assert property (@(posedge clk) disable iff (!rst_q)
    state == ST_CTRL && ev_byte_vld && !ev_start && !ev_stop &&
    ev_byte[3:1] != strap |=> ack_vld && !ack);

  // R7: no acknowledge during the internal write cycle
  a_r7_busy_nack: assert property (@(posedge clk) disable iff (!rst_q)
    busy && ev_byte_vld |=> ack_vld && !ack);

  // R6: a stop under write protect never starts a cycle
  a_r6_wp_block: assert property (@(posedge clk) disable iff (!rst_q)
    ev_stop && wp && !busy |=> !busy);

  // R5: the array is written only inside the write cycle
  a_r5_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_q)
    arr_we |-> busy);

  // R8: read data only appears outside the write cycle
  a_r8_tx_idle: assert property (@(posedge clk) disable iff (!rst_q)
    tx_vld |-> !$past(busy));
endmodule

// File: tb/ee_target_core_tb.sv
module ee_target_core_tb;
  localparam int PAGE = 128;
  localparam int MEM_AW = 10;
  localparam int DEPTH = 1 << MEM_AW;
  localparam int TWC = 160;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_start, ev_stop, ev_byte_vld, ev_mack_vld, ev_mack_ack, wp;
  logic [7:0] ev_byte;
  logic [2:0] strap;
  logic ack_vld, ack, tx_vld, busy;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  ee_target_core u_dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte), .ev_mack_vld(ev_mack_vld),
    .ev_mack_ack(ev_mack_ack), .strap(strap), .wp(wp), .ack_vld(ack_vld),
    .ack(ack), .tx_vld(tx_vld), .tx_data(tx_data), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R10";

  // reference model
  int mem [DEPTH];
  int pbuf [PAGE];
  int mstate = 0; // 0 idle 1 ctrl 2 ahi 3 alo 4 wdata 5 rdata
  int mptr = 0;
  int mahi = 0;
  bit mhas = 0;
  int left = 0;
  bit e_ackv = 0, e_ack = 0, e_txv = 0, e_busy = 0;
  int e_txd = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit s, bit p, bit bv, int b, bit mv, bit ma);
    bit busy_now, launch;
    int col;
    @(negedge clk);
    chk("ack_vld", int'(ack_vld), int'(e_ackv));
    if (e_ackv) chk("ack", int'(ack), int'(e_ack));
    chk("tx_vld", int'(tx_vld), int'(e_txv));
    if (e_txv) chk("tx_data", int'(tx_data), e_txd);
    chk("busy", int'(busy), int'(e_busy));
    ev_start = s; ev_stop = p; ev_byte_vld = bv; ev_byte = 8'(b);
    ev_mack_vld = mv; ev_mack_ack = ma;
    busy_now = left > 0;
    launch = 0;
    e_ackv = bv; e_ack = 0; e_txv = 0;
    if (!busy_now) begin
      if (s) mstate = 1;
      else if (p) begin
        if (mstate == 4 && mhas && !wp) launch = 1;
        mstate = 0;
      end else if (bv) begin
        case (mstate)
          1: if ((b >> 4) == 10 && ((b >> 1) & 7) == int'(strap)) begin
               e_ack = 1;
               if (b & 1) begin
                 mstate = 5; e_txv = 1; e_txd = mem[mptr];
                 mptr = (mptr + 1) % DEPTH;
               end else mstate = 2;
             end else mstate = 0;
          2: begin e_ack = 1; mahi = b; mstate = 3; end
          3: begin
               e_ack = 1; mptr = ((mahi << 8) | b) % DEPTH; mstate = 4; mhas = 0;
               for (int i = 0; i < PAGE; i++) pbuf[i] = -1;
             end
          4: begin
               e_ack = 1; mhas = 1; col = mptr % PAGE;
               pbuf[col] = b;
               mptr = mptr - col + ((col + 1) % PAGE);
             end
          default: ;
        endcase
      end else if (mv && mstate == 5) begin
        if (ma) begin
          e_txv = 1; e_txd = mem[mptr]; mptr = (mptr + 1) % DEPTH;
        end else mstate = 0;
      end
    end
    if (launch) begin
      for (int i = 0; i < PAGE; i++)
        if (pbuf[i] >= 0) mem[mptr - (mptr % PAGE) + i] = pbuf[i];
      left = TWC;
    end else if (left > 0) left--;
    e_busy = left > 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask
  task automatic t_start(); step(1, 0, 0, 0, 0, 0); endtask
  task automatic t_stop();  step(0, 1, 0, 0, 0, 0); endtask
  task automatic t_byte(int b); step(0, 0, 1, b, 0, 0); endtask
  task automatic t_mack(bit a); step(0, 0, 0, 0, 1, a); endtask
  task automatic wait_done(); while (left > 0) idle(1); idle(2); endtask

  function automatic int ctrl(bit rd);
    return 8'hA0 | (int'(strap) << 1) | int'(rd);
  endfunction

  task automatic set_addr(int a);
    t_start(); t_byte(ctrl(0)); t_byte((a >> 8) & 255); t_byte(a & 255);
  endtask

  task automatic wr(int a, int base, int n);
    set_addr(a);
    for (int i = 0; i < n; i++) t_byte((base + i) & 255);
    t_stop();
  endtask

  task automatic rd(int a, int n);
    set_addr(a);
    t_start(); t_byte(ctrl(1));
    for (int i = 1; i < n; i++) t_mack(1);
    t_mack(0); t_stop(); idle(1);
  endtask

  initial begin
    rst_n = 0; ev_start = 0; ev_stop = 0; ev_byte_vld = 0; ev_byte = 0;
    ev_mack_vld = 0; ev_mack_ack = 0; strap = 3'b101; wp = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    req = "R10"; idle(4);
    chk("reset busy", int'(busy), 0);

    req = "R5"; wr(16'h0105, 8'h30, 4);
    req = "R7"; idle(3); t_start(); t_byte(ctrl(0)); t_byte(0); t_stop(); wait_done();
    req = "R8"; rd(16'h0105, 4);
    req = "R2"; set_addr(16'h0106); t_stop(); idle(1);

    req = "R1"; strap = 3'b101;
    t_start(); step(0, 0, 1, 8'hA0 | (3'b011 << 1), 0, 0); t_byte(0); t_byte(5); t_stop();
    t_start(); step(0, 0, 1, 8'hB0 | (3'b101 << 1), 0, 0); t_byte(1); t_stop(); idle(2);
    strap = 3'b011; req = "R1"; wr(16'h0120, 8'h77, 1); wait_done();
    rd(16'h0120, 1); strap = 3'b101;

    req = "R4"; wr(16'h017E, 8'h50, 3); wait_done(); rd(16'h017E, 2); rd(16'h0100, 1);
    req = "R5"; wr(16'h0200, 8'h00, 130); wait_done(); rd(16'h0200, 4); rd(16'h027F, 1);

    req = "R6"; wp = 1; idle(1); wr(16'h0105, 8'hE0, 2); idle(4); wp = 0;
    rd(16'h0105, 2);

    req = "R9"; set_addr(16'h0105); t_byte(8'hAA); t_byte(8'hBB); t_start(); t_stop();
    idle(3); rd(16'h0105, 2);
    set_addr(16'h0106); t_stop(); idle(3);

    req = "R8"; wr(16'h03FF, 8'h91, 1); wait_done(); wr(16'h0000, 8'h92, 2); wait_done();
    rd(16'h03FF, 3);
    req = "R3"; rd(16'h0505, 2); rd(16'hFD00, 1);
    idle(2);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired in %s", req);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule